// File: doc/BRIEF.md
# ROM Page-Access Wait Controller

This block sets the number of wait states for reads from a ROM that supports page reads. When a bus cycle starts, it checks whether the new address falls in the same ROM page as the previous ROM cycle. A hit in the same page takes the short page wait count. A miss takes the longer normal wait count. When the selected number of wait cycles has passed, the block raises a one-cycle ready pulse.

The page size can be 8 or 16 bytes and is picked per cycle by a configuration input. The block keeps the address of the last ROM cycle. Any cycle to a region other than ROM drops that stored address, and so does reset, so the next ROM cycle is a miss. Address decoding and the data path stay outside the block. The bus tells the block which cycles target ROM through a select input.

Top module: `rom_page_wait`

## Requirements
- R1: While rst_ni is low, and after it is released, ready_o is low. No stored page is valid, so the first ROM cycle after reset uses the normal wait count.
- R2: A strobe is accepted when cyc_start_i is high at a rising clock edge and the block is idle or ready_o is high. For an accepted ROM strobe with selected count N, ready_o is high in exactly the one cycle that starts N edges after the accepting edge. With N = 0, that is the cycle right after the accepting edge.
- R3: A ROM cycle with no valid stored address, or with a stored address in a different page, takes wait_norm_i, which is a 3-bit count.
- R4: When page16_i = 0 (8-byte pages), a ROM cycle whose address bits [ADDR_W-1:3] equal those of the stored address takes wait_page_i, which is a 3-bit count.
- R5: When page16_i = 1 (16-byte pages), a hit needs only bits [ADDR_W-1:4] to match, and address bit 3 is ignored. The page size used is the value of page16_i at the accepting edge.
- R6: An accepted strobe with rom_sel_i = 0 never produces ready_o and clears the stored address, so the next ROM cycle takes wait_norm_i.
- R7: A strobe that arrives while a ROM cycle is still waiting, before its ready cycle, is ignored. It changes neither the ready timing nor the stored address.
- R8: A strobe given in the ready cycle is accepted, so ROM cycles can run back to back. The address of the finishing cycle is the one compared.
- R9: ready_o is a single-cycle pulse. After a ready cycle with no new strobe, ready_o is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Bus cycle start strobe |
| rom_sel_i | input | 1 | Cycle targets the ROM region |
| addr_i | input | ADDR_W | Byte address of the cycle |
| page16_i | input | 1 | Page size: 0 = 8 bytes, 1 = 16 bytes |
| wait_page_i | input | WAIT_W | Wait count for a same-page hit |
| wait_norm_i | input | WAIT_W | Wait count for an off-page access |
| ready_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle:
- **The end of one ROM cycle and the start of the next.** The bench drives a strobe during the ready cycle, to an address in the same page. It judges the result by checking that the second latency equals the page count, which shows that the finishing address was stored and compared in the very cycle the new strobe arrived.
- **A running count and a stray strobe.** The bench drives a non-ROM strobe halfway through a long wait. It judges the result by checking two things: the original latency is kept, and the next same-page ROM cycle still hits.

// File: rtl/rom_page_pkg.sv
package rom_page_pkg;
  typedef enum logic {
    PAGE_8B  = 1'b0,
    PAGE_16B = 1'b1
  } page_size_e;

  typedef struct packed {
    logic acc;   // strobe accepted this edge
    logic rom;   // accepted strobe targets ROM
  } cyc_req_t;
endpackage

// File: rtl/rom_page_track.sv
module rom_page_track #(
  parameter int ADDR_W = 24,
  parameter int MIN_LG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rom_page_pkg::cyc_req_t req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  rom_page_pkg::page_size_e page_sz_i,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - MIN_LG;

  logic [TAG_W-1:0] prev_q;
  logic             valid_q;
  logic [TAG_W-1:0] diff;

  // lowest tag bit is a don't-care for the wider page
  generate
    for (genvar g = 0; g < TAG_W; g++) begin : g_cmp
      if (g == 0) begin : g_lsb
        assign diff[g] = (prev_q[g] ^ addr_i[MIN_LG+g]) &&
                         (page_sz_i == rom_page_pkg::PAGE_8B);
      end else begin : g_hi
        assign diff[g] = prev_q[g] ^ addr_i[MIN_LG+g];
      end
    end
  endgenerate

  assign hit_o = valid_q && (diff == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
    end else if (req_i.acc) begin
      valid_q <= req_i.rom;
      if (req_i.rom) prev_q <= addr_i[ADDR_W-1:MIN_LG];
    end
  end
endmodule

// File: rtl/rom_wait_timer.sv
module rom_wait_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] cnt_i,
  output logic              busy_o,
  output logic              ready_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              busy_q;

  assign busy_o  = busy_q;
  assign ready_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= cnt_i;
      busy_q <= 1'b1;
    end else if (ready_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rom_wait_sel.sv
module rom_wait_sel #(
  parameter int WAIT_W = 3
) (
  input  logic              hit_i,
  input  logic [WAIT_W-1:0] wait_page_i,
  input  logic [WAIT_W-1:0] wait_norm_i,
  output logic [WAIT_W-1:0] wait_o
);
  always_comb begin
    wait_o = hit_i ? wait_page_i : wait_norm_i;
  end
endmodule

// File: rtl/rom_page_wait.sv
module rom_page_wait #(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 3,
  parameter int MIN_LG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_start_i,
  input  logic              rom_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              page16_i,
  input  logic [WAIT_W-1:0] wait_page_i,
  input  logic [WAIT_W-1:0] wait_norm_i,
  output logic              ready_o
);
  import rom_page_pkg::*;

  logic        busy;
  logic        hit;
  cyc_req_t    req;
  page_size_e  page_sz;
  logic [WAIT_W-1:0] wait_sel;

  // a new strobe is taken when idle or in the completing cycle
  assign req.acc = cyc_start_i && (!busy || ready_o);
  assign req.rom = rom_sel_i;
  assign page_sz = page16_i ? PAGE_16B : PAGE_8B;

  rom_page_track #(.ADDR_W(ADDR_W), .MIN_LG(MIN_LG)) i_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .addr_i    (addr_i),
    .page_sz_i (page_sz),
    .hit_o     (hit)
  );

  rom_wait_sel #(.WAIT_W(WAIT_W)) i_sel (
    .hit_i       (hit),
    .wait_page_i (wait_page_i),
    .wait_norm_i (wait_norm_i),
    .wait_o      (wait_sel)
  );

  rom_wait_timer #(.WAIT_W(WAIT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (req.acc && req.rom),
    .cnt_i   (wait_sel),
    .busy_o  (busy),
    .ready_o (ready_o)
  );
endmodule

// File: rtl/rom_page_wait_chk.sv
module rom_page_wait_chk #(
  parameter int WAIT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_start_i,
  input logic              rom_sel_i,
  input logic [WAIT_W-1:0] wait_page_i,
  input logic [WAIT_W-1:0] wait_norm_i,
  input logic              busy,
  input logic              ready_o
);
  logic acc;
  assign acc = cyc_start_i && (!busy || ready_o);

  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!ready_o);
  end

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !cyc_start_i |=> !ready_o);

  a_r6_other_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !rom_sel_i |=> !ready_o);

  a_r2_zero_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && rom_sel_i && wait_page_i == '0 && wait_norm_i == '0 |=> ready_o);

  a_r2_nonzero_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && rom_sel_i && wait_page_i != '0 && wait_norm_i != '0 |=> !ready_o);

  a_r7_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !ready_o |=> busy);
endmodule

bind rom_page_wait rom_page_wait_chk #(.WAIT_W(WAIT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_start_i (cyc_start_i),
  .rom_sel_i   (rom_sel_i),
  .wait_page_i (wait_page_i),
  .wait_norm_i (wait_norm_i),
  .busy        (busy),
  .ready_o     (ready_o)
);

// File: tb/test_rom_page_wait.sv
`timescale 1ns/1ps
module test_rom_page_wait;
  localparam int ADDR_W = 24;
  localparam int WAIT_W = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cyc_start_i = 1'b0;
  logic              rom_sel_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              page16_i = 1'b0;
  logic [WAIT_W-1:0] wait_page_i = '0;
  logic [WAIT_W-1:0] wait_norm_i = '0;
  logic              ready_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit m_valid = 0;
  logic [ADDR_W-1:0] m_prev = '0;

  always #2.5 clk_i = ~clk_i;

  rom_page_wait #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_rom_page_wait (.*);

  function automatic bit exp_hit(logic [ADDR_W-1:0] a, bit p16);
    if (!m_valid) return 0;
    if (p16) return m_prev[ADDR_W-1:4] == a[ADDR_W-1:4];
    return m_prev[ADDR_W-1:3] == a[ADDR_W-1:3];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_lat(output int lat);
    lat = 0;
    while (!ready_o && lat < 12) begin
      @(posedge clk_i); #1;
      lat++;
    end
  endtask

  task automatic rom_access(logic [ADDR_W-1:0] a, bit p16,
                            logic [WAIT_W-1:0] wp, logic [WAIT_W-1:0] wn,
                            string req);
    int lat;
    int exp;
    exp = exp_hit(a, p16) ? int'(wp) : int'(wn);
    @(negedge clk_i);
    cyc_start_i = 1; rom_sel_i = 1; addr_i = a; page16_i = p16;
    wait_page_i = wp; wait_norm_i = wn;
    @(posedge clk_i); #1;
    cyc_start_i = 0;
    count_lat(lat);
    chk(lat == exp, req, lat, exp);
    m_valid = 1; m_prev = a;
    @(posedge clk_i); #1;
    chk(!ready_o, "R9 pulse", int'(ready_o), 0);
  endtask

  task automatic other_access(logic [ADDR_W-1:0] a);
    bit seen;
    seen = 0;
    @(negedge clk_i);
    cyc_start_i = 1; rom_sel_i = 0; addr_i = a;
    @(posedge clk_i); #1;
    cyc_start_i = 0;
    for (int i = 0; i < 9; i++) begin
      if (ready_o) seen = 1;
      @(posedge clk_i); #1;
    end
    chk(!seen, "R6 no ready", int'(seen), 0);
    m_valid = 0;
  endtask

  initial begin
    int lat;
    void'($urandom(32'h1b5e));
    #1;
    chk(!ready_o, "R1 in reset", int'(ready_o), 0);
    #20 rst_ni = 1;
    @(posedge clk_i); #1;
    chk(!ready_o, "R1 after reset", int'(ready_o), 0);

    // first access after reset is off-page
    rom_access(24'h001000, 0, 3'd1, 3'd5, "R1 first miss");
    rom_access(24'h001007, 0, 3'd1, 3'd5, "R4 hit 8B");
    rom_access(24'h001008, 0, 3'd1, 3'd5, "R3 miss 8B");
    rom_access(24'h00100F, 1, 3'd2, 3'd6, "R5 hit 16B bit3");
    rom_access(24'h001010, 1, 3'd2, 3'd6, "R5 miss 16B");
    rom_access(24'h001011, 0, 3'd0, 3'd7, "R2 zero wait hit");
    rom_access(24'h120011, 0, 3'd0, 3'd0, "R2 zero wait miss");
    other_access(24'h120012);
    rom_access(24'h120013, 0, 3'd1, 3'd4, "R6 miss after other");

    // R7: strobe mid-wait ignored
    @(negedge clk_i);
    cyc_start_i = 1; rom_sel_i = 1; addr_i = 24'h400020;
    wait_page_i = 3'd2; wait_norm_i = 3'd6; page16_i = 0;
    @(posedge clk_i); #1;
    cyc_start_i = 0;
    @(posedge clk_i); #1;
    @(posedge clk_i); #1;
    cyc_start_i = 1; rom_sel_i = 0; addr_i = 24'h777777;
    @(posedge clk_i); #1;
    cyc_start_i = 0; rom_sel_i = 1;
    lat = 3;
    while (!ready_o && lat < 12) begin @(posedge clk_i); #1; lat++; end
    chk(lat == 6, "R7 timing kept", lat, 6);
    m_valid = 1; m_prev = 24'h400020;
    @(posedge clk_i); #1;
    rom_access(24'h400021, 0, 3'd2, 3'd6, "R7 prev kept");

    // R8: back-to-back strobe in ready cycle
    @(negedge clk_i);
    cyc_start_i = 1; rom_sel_i = 1; addr_i = 24'h500000;
    wait_page_i = 3'd1; wait_norm_i = 3'd3;
    @(posedge clk_i); #1;
    cyc_start_i = 0;
    count_lat(lat);
    chk(lat == 3, "R8 first", lat, 3);
    cyc_start_i = 1; addr_i = 24'h500004;
    @(posedge clk_i); #1;
    cyc_start_i = 0;
    count_lat(lat);
    chk(lat == 1, "R8 back-to-back hit", lat, 1);
    m_valid = 1; m_prev = 24'h500004;
    @(posedge clk_i); #1;
    chk(!ready_o, "R9 after b2b", int'(ready_o), 0);

    for (int k = 0; k < 300; k++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom % 4 == 0) ? ADDR_W'($urandom) : (m_prev ^ ADDR_W'($urandom % 32));
      if ($urandom % 6 == 0) other_access(a);
      else rom_access(a, 1'($urandom), WAIT_W'($urandom), WAIT_W'($urandom), "R3/R4/R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule